// File: doc/BRIEF.md
# Double-Buffered Channel Profile Loader

This block fills the tap tables of a bank of channel-emulation FIR filters from a host. The host sends 32-bit words over a valid/ready stream. The words land in a small FIFO. A sequencer splits each word into two 16-bit half-words and writes them into one of two profile banks. A profile holds a path-gain coefficient and a delay value for every tap of every filter, plus a small scale exponent.

One bank is active. The filters read it through a registered read port, and its exponent is presented continuously. The other bank is the shadow, and the next profile is written there. A refresh tick swaps the banks only if the shadow holds a complete profile. If the shadow is incomplete, the active profile stays in place, a one-cycle underrun pulse is raised, and loading carries on. Once a profile is complete, the loader stops taking words until the next swap. Words that arrive meanwhile wait in the FIFO and then push back on the host.

Top module: `profile_loader`

## Requirements
- R1: After reset the active bank is 0, the active exponent is 0, underrun is 0, `s_ready` is 1, and every read returns 0 for both coefficient and delay.
- R2: A profile is NUM_FILT*NUM_TAP/2 coefficient words, then the same number of delay words, then one exponent word. Entry index is filter*NUM_TAP+tap. Word w of a section carries entry 2w in bits [15:0] and entry 2w+1 in bits [31:16]. The exponent is bits [3:0] of the last word, and bits [31:4] of that word are ignored.
- R3: Writing a profile into the shadow bank never changes what the read port or the exponent output show before a swap.
- R4: A refresh tick while the shadow is complete swaps the banks: `act_bank` toggles on the clock edge that samples the tick, and from then on reads and `act_kh` return the new profile.
- R5: A refresh tick while the shadow is incomplete leaves the active bank and its contents unchanged. It raises `underrun` for exactly one cycle, and the partial load continues, so a later complete profile swaps in normally.
- R6: While the shadow is complete and no swap has occurred, no word is taken from the FIFO. The FIFO fills to NUM_FIFO words and then drops `s_ready`, and the held words start the next profile after the swap with none lost.
- R7: `s_ready` is high whenever the FIFO holds fewer than FIFO_DEPTH words, and a word is accepted exactly when `s_valid` and `s_ready` are both high at a clock edge.
- R8: A read address presented before a clock edge yields its coefficient and delay on `rd_coef`/`rd_delay` after that edge (one-cycle latency), taken from the bank active at that edge.
- R9: `act_bank` changes only on an edge that samples `refresh_tick` high, and an underrun pulse never coincides with a bank change.
- R10: The exponent travels with its profile: after successive swaps `act_kh` always equals the exponent loaded with the profile currently active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Host word valid |
| s_data | input | 32 | Host word: two packed 16-bit half-words |
| s_ready | output | 1 | FIFO can accept a word |
| refresh_tick | input | 1 | One-cycle refresh request |
| rd_filt | input | 2 | Filter index of the read |
| rd_tap | input | 5 | Tap index of the read |
| rd_coef | output | 16 | Registered coefficient of the addressed tap |
| rd_delay | output | 16 | Registered delay of the addressed tap |
| act_kh | output | 4 | Scale exponent of the active profile |
| act_bank | output | 1 | Index of the active bank |
| underrun | output | 1 | One-cycle pulse: tick arrived with an incomplete shadow |

## Verification
The hardest state to reach is a complete shadow profile parked behind a full FIFO. In that state the loader refuses words, the host is throttled, and the held words must still form the start of the following profile. The stimulus first loads a full profile without ticking. It then pushes the first words of the next profile and watches `s_ready` fall. After that it ticks, finishes the second profile, and ticks again, comparing every tap. A tick issued halfway through a load reaches the underrun path in the same run.

// File: rtl/pl_pkg.sv
`timescale 1ns/1ps
package pl_pkg;

    typedef enum logic [1:0] {
        SEC_COEF  = 2'd0,
        SEC_DELAY = 2'd1,
        SEC_KH    = 2'd2
    } sec_e;

endpackage

// File: rtl/pl_fifo.sv
`timescale 1ns/1ps
module pl_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         in_ready,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         pop
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [CW-1:0]           cnt;
    } st_t;

    st_t s_q, s_d;
    logic push;

    assign in_ready  = (s_q.cnt != CW'(DEPTH));
    assign out_valid = (s_q.cnt != '0);
    assign out_data  = s_q.mem[s_q.rp];
    assign push      = in_valid && in_ready;

    always_comb begin
        s_d = s_q;
        if (push) begin
            s_d.mem[s_q.wp] = in_data;
            s_d.wp = (s_q.wp == PW'(DEPTH - 1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop) begin
            s_d.rp = (s_q.rp == PW'(DEPTH - 1)) ? '0 : s_q.rp + 1'b1;
        end
        case ({push, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (s_q.cnt != '0));

    assert_count_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));

    assert_full_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !pop) |=> !in_ready);

endmodule

// File: rtl/pl_seq.sv
`timescale 1ns/1ps
module pl_seq
    import pl_pkg::*;
#(
    parameter int HW      = 16,
    parameter int ENTRIES = 72,
    parameter int KH_W    = 4,
    parameter int IW      = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            word_valid,
    input  logic [2*HW-1:0] word_data,
    output logic            pop,
    input  logic            tick,
    output logic            wr_en,
    output sec_e            wr_sec,
    output logic            wr_bank,
    output logic [IW-1:0]   wr_idx,
    output logic [HW-1:0]   wr_lo,
    output logic [HW-1:0]   wr_hi,
    output logic            act_bank,
    output logic [KH_W-1:0] act_kh,
    output logic            underrun
);
    localparam int HALF  = ENTRIES / 2;
    localparam int TOTAL = 2 * HALF + 1;
    localparam int WCW   = $clog2(TOTAL);

    typedef struct packed {
        logic [WCW-1:0]         wcnt;
        logic                   done;
        logic                   act;
        logic [1:0][KH_W-1:0]   kh;
        logic                   under;
    } st_t;

    st_t s_q, s_d;
    sec_e sec;
    logic [IW-1:0] idx;

    always_comb begin
        s_d = s_q;
        sec = SEC_KH;
        idx = '0;
        if (s_q.wcnt < WCW'(HALF)) begin
            sec = SEC_COEF;
            idx = IW'(s_q.wcnt) << 1;
        end else if (s_q.wcnt < WCW'(2 * HALF)) begin
            sec = SEC_DELAY;
            idx = IW'(s_q.wcnt - WCW'(HALF)) << 1;
        end
        pop = word_valid && !s_q.done;
        s_d.under = 1'b0;
        if (pop) begin
            if (s_q.wcnt == WCW'(TOTAL - 1)) begin
                s_d.wcnt         = '0;
                s_d.done         = 1'b1;
                s_d.kh[~s_q.act] = word_data[KH_W-1:0];
            end else begin
                s_d.wcnt = s_q.wcnt + 1'b1;
            end
        end
        if (tick) begin
            if (s_q.done) begin
                s_d.act  = ~s_q.act;
                s_d.done = 1'b0;
            end else begin
                s_d.under = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wr_en    = pop && (sec != SEC_KH);
    assign wr_sec   = sec;
    assign wr_bank  = ~s_q.act;
    assign wr_idx   = idx;
    assign wr_lo    = word_data[HW-1:0];
    assign wr_hi    = word_data[2*HW-1:HW];
    assign act_bank = s_q.act;
    assign act_kh   = s_q.kh[s_q.act];
    assign underrun = s_q.under;

    assert_swap_on_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && s_q.done) |=> (act_bank != $past(act_bank)) && !underrun);

    assert_keep_on_underrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !s_q.done) |=> underrun && $stable(act_bank) && $stable(act_kh));

    assert_hold_when_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !pop);

    assert_bank_moves_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (act_bank != $past(act_bank)) |-> $past(tick));

    assert_kh_stable_without_swap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(act_kh));

endmodule

// File: rtl/pl_store.sv
`timescale 1ns/1ps
module pl_store
    import pl_pkg::*;
#(
    parameter int HW      = 16,
    parameter int ENTRIES = 72,
    parameter int IW      = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  sec_e          wr_sec,
    input  logic          wr_bank,
    input  logic [IW-1:0] wr_idx,
    input  logic [HW-1:0] wr_lo,
    input  logic [HW-1:0] wr_hi,
    input  logic          rd_bank,
    input  logic [IW-1:0] rd_idx,
    output logic [HW-1:0] rd_coef,
    output logic [HW-1:0] rd_delay
);
    typedef struct packed {
        logic [1:0][ENTRIES-1:0][HW-1:0] coef;
        logic [1:0][ENTRIES-1:0][HW-1:0] dly;
        logic [HW-1:0]                   coef_out;
        logic [HW-1:0]                   dly_out;
    } st_t;

    st_t s_q, s_d;
    logic [IW-1:0] idx_hi;

    assign idx_hi = wr_idx | IW'(1);

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            if (wr_sec == SEC_COEF) begin
                s_d.coef[wr_bank][wr_idx] = wr_lo;
                s_d.coef[wr_bank][idx_hi] = wr_hi;
            end else if (wr_sec == SEC_DELAY) begin
                s_d.dly[wr_bank][wr_idx] = wr_lo;
                s_d.dly[wr_bank][idx_hi] = wr_hi;
            end
        end
        if (rd_idx < IW'(ENTRIES)) begin
            s_d.coef_out = s_q.coef[rd_bank][rd_idx];
            s_d.dly_out  = s_q.dly[rd_bank][rd_idx];
        end else begin
            s_d.coef_out = '0;
            s_d.dly_out  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_coef  = s_q.coef_out;
    assign rd_delay = s_q.dly_out;

    assert_shadow_only_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_bank != rd_bank));

    assert_even_pair_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!wr_idx[0] && (wr_idx < IW'(ENTRIES))));

endmodule

// File: rtl/profile_loader.sv
`timescale 1ns/1ps
module profile_loader
    import pl_pkg::*;
#(
    parameter int NUM_FILT   = 4,
    parameter int NUM_TAP    = 18,
    parameter int COEF_W     = 16,
    parameter int KH_W       = 4,
    parameter int FIFO_DEPTH = 4,
    localparam int DW        = 2 * COEF_W,
    localparam int FILT_W    = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1,
    localparam int TAP_W     = (NUM_TAP > 1) ? $clog2(NUM_TAP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic [DW-1:0]     s_data,
    output logic              s_ready,
    input  logic              refresh_tick,
    input  logic [FILT_W-1:0] rd_filt,
    input  logic [TAP_W-1:0]  rd_tap,
    output logic [COEF_W-1:0] rd_coef,
    output logic [COEF_W-1:0] rd_delay,
    output logic [KH_W-1:0]   act_kh,
    output logic              act_bank,
    output logic              underrun
);
    localparam int ENTRIES = NUM_FILT * NUM_TAP;
    localparam int IW      = $clog2(ENTRIES + 1);

    logic              f_valid;
    logic [DW-1:0]     f_data;
    logic              f_pop;
    logic              wr_en;
    sec_e              wr_sec;
    logic              wr_bank;
    logic [IW-1:0]     wr_idx;
    logic [COEF_W-1:0] wr_lo;
    logic [COEF_W-1:0] wr_hi;
    logic [IW-1:0]     rd_idx;

    always_comb begin
        if (rd_tap >= TAP_W'(NUM_TAP))
            rd_idx = IW'(ENTRIES);
        else
            rd_idx = IW'(rd_filt) * IW'(NUM_TAP) + IW'(rd_tap);
    end

    pl_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (s_valid),
        .in_data  (s_data),
        .in_ready (s_ready),
        .out_valid(f_valid),
        .out_data (f_data),
        .pop      (f_pop)
    );

    pl_seq #(.HW(COEF_W), .ENTRIES(ENTRIES), .KH_W(KH_W), .IW(IW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_valid(f_valid),
        .word_data (f_data),
        .pop       (f_pop),
        .tick      (refresh_tick),
        .wr_en     (wr_en),
        .wr_sec    (wr_sec),
        .wr_bank   (wr_bank),
        .wr_idx    (wr_idx),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .act_bank  (act_bank),
        .act_kh    (act_kh),
        .underrun  (underrun)
    );

    pl_store #(.HW(COEF_W), .ENTRIES(ENTRIES), .IW(IW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sec  (wr_sec),
        .wr_bank (wr_bank),
        .wr_idx  (wr_idx),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .rd_bank (act_bank),
        .rd_idx  (rd_idx),
        .rd_coef (rd_coef),
        .rd_delay(rd_delay)
    );

endmodule

// File: tb/profile_loader_test.sv
`timescale 1ns/1ps
module profile_loader_test;
    localparam int NF = 4;
    localparam int NT = 18;
    localparam int NE = NF * NT;
    localparam int HALF = NE / 2;
    localparam int TOTAL = 2 * HALF + 1;
    localparam int FD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic s_valid = 1'b0;
    logic [31:0] s_data = '0;
    logic s_ready;
    logic refresh_tick = 1'b0;
    logic [1:0] rd_filt = '0;
    logic [4:0] rd_tap = '0;
    logic [15:0] rd_coef, rd_delay;
    logic [3:0] act_kh;
    logic act_bank, underrun;

    int n_cmp = 0;
    int n_bad = 0;

    logic [15:0] nx_coef [NE];
    logic [15:0] nx_dly  [NE];
    logic [3:0]  nx_kh;
    logic [27:0] nx_junk;
    logic [15:0] sh_coef [NE];
    logic [15:0] sh_dly  [NE];
    logic [3:0]  sh_kh;
    logic [15:0] ac_coef [NE];
    logic [15:0] ac_dly  [NE];
    logic [3:0]  ac_kh;
    logic        exp_bank;

    always #2.5 clk = ~clk;

    profile_loader #(.FIFO_DEPTH(FD)) uut (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .refresh_tick(refresh_tick), .rd_filt(rd_filt), .rd_tap(rd_tap),
        .rd_coef(rd_coef), .rd_delay(rd_delay), .act_kh(act_kh),
        .act_bank(act_bank), .underrun(underrun)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] prof_word(int w);
        if (w < HALF)            return {nx_coef[2*w+1], nx_coef[2*w]};
        else if (w < 2 * HALF)   return {nx_dly[2*(w-HALF)+1], nx_dly[2*(w-HALF)]};
        else                     return {nx_junk, nx_kh};
    endfunction

    task automatic gen_profile();
        for (int i = 0; i < NE; i++) begin
            nx_coef[i] = 16'($urandom);
            nx_dly[i]  = 16'($urandom);
        end
        nx_kh   = 4'($urandom);
        nx_junk = 28'($urandom);
    endtask

    task automatic save_shadow();
        for (int i = 0; i < NE; i++) begin
            sh_coef[i] = nx_coef[i];
            sh_dly[i]  = nx_dly[i];
        end
        sh_kh = nx_kh;
    endtask

    task automatic shadow_to_active();
        for (int i = 0; i < NE; i++) begin
            ac_coef[i] = sh_coef[i];
            ac_dly[i]  = sh_dly[i];
        end
        ac_kh = sh_kh;
        exp_bank = ~exp_bank;
    endtask

    task automatic send_words(int first, int last);
        for (int w = first; w <= last; w++) begin
            @(negedge clk);
            s_valid = 1'b1;
            s_data  = prof_word(w);
            while (!s_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        s_valid = 1'b0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_tick();
        @(negedge clk);
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
    endtask

    task automatic read_one(string req, int f, int t);
        @(negedge clk);
        rd_filt = 2'(f);
        rd_tap  = 5'(t);
        @(negedge clk);
        chk(req, $sformatf("coef f%0d t%0d", f, t), 32'(rd_coef), 32'(ac_coef[f*NT+t]));
        chk(req, $sformatf("delay f%0d t%0d", f, t), 32'(rd_delay), 32'(ac_dly[f*NT+t]));
    endtask

    task automatic check_all(string req);
        for (int f = 0; f < NF; f++)
            for (int t = 0; t < NT; t++)
                read_one(req, f, t);
        chk(req, "act_kh", 32'(act_kh), 32'(ac_kh));
        chk(req, "act_bank", 32'(act_bank), 32'(exp_bank));
    endtask

    initial begin
        #(5.0 * 100000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog (R1..all) actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5EED));
        for (int i = 0; i < NE; i++) begin
            ac_coef[i] = '0;
            ac_dly[i]  = '0;
        end
        ac_kh = '0;
        exp_bank = 1'b0;
        idle(4);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        chk("R1", "act_bank", 32'(act_bank), 32'd0);
        chk("R1", "act_kh", 32'(act_kh), 32'd0);
        chk("R1", "underrun", 32'(underrun), 32'd0);
        chk("R1 R7", "s_ready", 32'(s_ready), 32'd1);
        read_one("R1", 0, 0);
        read_one("R1", NF-1, NT-1);

        // Profile A with extreme corner values
        gen_profile();
        nx_coef[0] = 16'hFFFF;
        nx_dly[NE-1] = 16'h0000;
        nx_coef[NE-1] = 16'h8000;
        send_words(0, TOTAL-1);
        save_shadow();
        idle(FD + 4);
        // R3: still the reset profile while shadow holds A
        read_one("R3", 0, 0);
        read_one("R3", 2, 7);
        chk("R3", "act_kh before swap", 32'(act_kh), 32'd0);
        do_tick();
        shadow_to_active();
        chk("R4", "act_bank after tick", 32'(act_bank), 32'(exp_bank));
        chk("R4 R9", "underrun on good tick", 32'(underrun), 32'd0);
        check_all("R2 R4 R8");

        // Profile B: tick halfway through -> underrun
        gen_profile();
        send_words(0, HALF - 1);
        do_tick();
        chk("R5", "underrun pulse", 32'(underrun), 32'd1);
        chk("R5 R9", "bank kept", 32'(act_bank), 32'(exp_bank));
        @(negedge clk);
        chk("R5", "underrun one cycle", 32'(underrun), 32'd0);
        check_all("R5");
        send_words(HALF, TOTAL-1);
        save_shadow();
        idle(FD + 4);
        do_tick();
        shadow_to_active();
        check_all("R5 R10");

        // Profile C complete, then D's first words stall in the FIFO
        gen_profile();
        send_words(0, TOTAL-1);
        save_shadow();
        idle(FD + 4);
        gen_profile();
        send_words(0, FD - 1);
        idle(3);
        chk("R6", "s_ready low with full fifo", 32'(s_ready), 32'd0);
        read_one("R3 R6", 1, 5);
        do_tick();
        shadow_to_active();
        check_all("R6 R10");
        idle(2);
        chk("R7", "s_ready back after drain", 32'(s_ready), 32'd1);
        send_words(FD, TOTAL-1);
        save_shadow();
        idle(FD + 4);
        do_tick();
        shadow_to_active();
        check_all("R2 R6");

        // Nothing pending: tick is an underrun, active profile kept
        do_tick();
        chk("R5", "underrun empty shadow", 32'(underrun), 32'd1);
        chk("R9", "bank kept on empty", 32'(act_bank), 32'(exp_bank));
        chk("R10", "kh kept on empty", 32'(act_kh), 32'(ac_kh));
        read_one("R5", 3, 17);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule